// File: doc/BRIEF.md
# Strap-Latched Clock Configuration Controller

This block is the digital control core of a multi-output clock generator. After reset it samples a five-bit frequency-select strap from pins that later carry clock outputs. While it samples, it keeps those pins' output drivers off. Once sampling completes it turns the pins into outputs and never samples them again.

The frequency code sent to the synthesizer comes from one of two places: the latched strap, or a code field held in a small register bank. A select bit in that bank chooses between them. The bank is written and read through a simple parallel port that stands behind the serial interface.

The block also gates eighteen clock outputs: four processor-domain, eleven bus-domain and three mid-rate. Each gate changes only while its source clock is low, so no gated output can produce a runt pulse. An asynchronous active-low power-down input forces every output low immediately. When power-down is released, the outputs stay off for a programmable number of reference cycles while the PLL relocks. A 24/48 MHz select input is registered and passed on.

Top module: `clkcfg_ctrl`

## Requirements
- R1: After reset is released, `strap_done` and `pin_oe` are 0 for the first reference edge and become 1 at the second edge. The strap value present at that second edge is latched, and later changes on `strap_in` do not change `fs_code`.
- R2: When register 0 bit 3 is 0, `fs_code` equals the latched strap. When it is 1, `fs_code` is {reg0 bit 2, reg0 bits 7:4}.
- R3: Reset and readback values are as follows. Reg0 resets to 0x00 and reads back all 8 bits. Reg1 holds the processor enables in bits 3:0 and resets to 0x0F. Reg2 holds bus enables 7..0 and resets to 0xFF. Reg3 holds the mid-rate enables in bits 2:0 and resets to 0x07. Reg4 holds bus enables 10..8 in bits 2:0 and resets to 0x07. Reg5 holds the lock-wait count and resets to 0x04. Bits that are not implemented read as 0.
- R4: `gate_en` is arranged as [3:0] processor, [14:4] bus 0..10 and [17:15] mid-rate. After a register write, each gate takes its enable bit at the next edge where its `clk_lvl` bit is 0, provided sampling is done and no power-down wait is active. A disabled output's `gclk` stays 0.
- R5: A `gate_en` bit never changes at an edge where its `clk_lvl` bit was 1.
- R6: While `pd_n` is 0, every `gclk` bit is 0 with no clock delay. `pll_en` falls two edges after `pd_n` falls.
- R7: When `pd_n` rises with a wait count W, `pll_en` rises after two edges. With `clk_lvl` low, gates stay 0 through edge 2+W and turn on at edge 3+W, counting the first edge after the rise as edge 0.
- R8: Writes to address 6 or 7 have no effect: those addresses read 0x00, and registers, gates and `fs_code` are unchanged.
- R9: `sel24` follows `sel_in` one reference edge later (1 selects 24 MHz, 0 selects 48 MHz).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| strap_in | input | 5 | Frequency-select strap levels on the shared pins |
| pin_oe | output | 1 | Output-drive enable for the shared pins |
| strap_done | output | 1 | Strap sampling finished |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 8 | Register write data |
| rd_addr | input | 3 | Register read address |
| rd_data | output | 8 | Register read data (combinational) |
| pd_n | input | 1 | Asynchronous active-low power-down |
| sel_in | input | 1 | 24/48 MHz select input |
| sel24 | output | 1 | Registered 24/48 MHz select |
| clk_lvl | input | 18 | Current level of each ungated source clock |
| gate_en | output | 18 | Per-output gate state |
| gclk | output | 18 | Gated clock levels |
| fs_code | output | 5 | Frequency code to the synthesizer |
| pll_en | output | 1 | PLL enable |

## Verification
The bench changes the strap after sampling is done. A controller that keeps sampling would let `fs_code` drift when it should hold. The bench also writes enables while the source levels are high; a design that updated gates at once would cut a high phase short and create a runt. The power-down release is timed to the exact edge on which gates return, which catches an off-by-one in the lock wait or the synchronizer. Writes to the reserved addresses are checked for leaks into readback, gates and the frequency code.

// File: rtl/clkcfg_pkg.sv
package clkcfg_pkg;
    localparam int FS_W     = 5;
    localparam int ADDR_W   = 3;
    localparam int DATA_W   = 8;
    localparam int NUM_CPU  = 4;
    localparam int NUM_PCI  = 11;
    localparam int NUM_V66  = 3;
    localparam int NUM_OUT  = NUM_CPU + NUM_PCI + NUM_V66;
    localparam int PCI_LO   = 8;
    localparam int PCI_HI   = NUM_PCI - PCI_LO;
    localparam int SRC_BIT  = 3;
    localparam int CODE_MSB_BIT = 2;
    localparam int STRAP_CYC = 2;
    localparam logic [DATA_W-1:0] LOCK_DEF = 8'd4;

    typedef enum logic [ADDR_W-1:0] {
        A_MODE = 3'd0,
        A_CPU  = 3'd1,
        A_PCIL = 3'd2,
        A_V66  = 3'd3,
        A_PCIH = 3'd4,
        A_LOCK = 3'd5
    } reg_addr_e;

    typedef struct packed {
        logic [DATA_W-1:0]  mode;
        logic [NUM_CPU-1:0] cpu_en;
        logic [NUM_PCI-1:0] pci_en;
        logic [NUM_V66-1:0] v66_en;
        logic [DATA_W-1:0]  lock_wait;
    } cfg_t;

    function automatic logic [FS_W-1:0] pick_code(input cfg_t c, input logic [FS_W-1:0] strap);
        logic [FS_W-1:0] r;
        r = {c.mode[CODE_MSB_BIT], c.mode[DATA_W-1:DATA_W-4]};
        return c.mode[SRC_BIT] ? r : strap;
    endfunction

    function automatic logic [NUM_OUT-1:0] en_vector(input cfg_t c);
        return {c.v66_en, c.pci_en, c.cpu_en};
    endfunction
endpackage

// File: rtl/clkcfg_strap.sv
module clkcfg_strap
    import clkcfg_pkg::*;
#(
    parameter int CYC = STRAP_CYC
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [FS_W-1:0] strap_in,
    output logic [FS_W-1:0] strap_q,
    output logic            done
);
    localparam int CW = $clog2(CYC + 1);
    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt     <= '0;
            done    <= 1'b0;
            strap_q <= '0;
        end else if (!done) begin
            if (cnt == CW'(CYC - 1)) begin
                strap_q <= strap_in;
                done    <= 1'b1;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end

    assert_strap_frozen_R1: assert property (@(posedge clk) disable iff (rst)
        (done && $past(done)) |-> $stable(strap_q));
endmodule

// File: rtl/clkcfg_regs.sv
module clkcfg_regs
    import clkcfg_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output cfg_t              cfg
);
    always_ff @(posedge clk) begin
        if (rst) begin
            cfg.mode      <= '0;
            cfg.cpu_en    <= '1;
            cfg.pci_en    <= '1;
            cfg.v66_en    <= '1;
            cfg.lock_wait <= LOCK_DEF;
        end else if (wr_en) begin
            case (wr_addr)
                A_MODE: cfg.mode                     <= wr_data;
                A_CPU:  cfg.cpu_en                   <= wr_data[NUM_CPU-1:0];
                A_PCIL: cfg.pci_en[PCI_LO-1:0]       <= wr_data[PCI_LO-1:0];
                A_V66:  cfg.v66_en                   <= wr_data[NUM_V66-1:0];
                A_PCIH: cfg.pci_en[NUM_PCI-1:PCI_LO] <= wr_data[PCI_HI-1:0];
                A_LOCK: cfg.lock_wait                <= wr_data;
                default: ;
            endcase
        end
    end

    always_comb begin
        case (rd_addr)
            A_MODE:  rd_data = cfg.mode;
            A_CPU:   rd_data = DATA_W'(cfg.cpu_en);
            A_PCIL:  rd_data = cfg.pci_en[PCI_LO-1:0];
            A_V66:   rd_data = DATA_W'(cfg.v66_en);
            A_PCIH:  rd_data = DATA_W'(cfg.pci_en[NUM_PCI-1:PCI_LO]);
            A_LOCK:  rd_data = cfg.lock_wait;
            default: rd_data = '0;
        endcase
    end

    assert_reserved_inert_R8: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_addr >= 3'd6) |=> $stable(cfg));
endmodule

// File: rtl/clkcfg_pwr.sv
module clkcfg_pwr
    import clkcfg_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              pd_n,
    input  logic [DATA_W-1:0] wait_val,
    output logic              pll_en,
    output logic              blocked
);
    logic              s1, s2;
    logic [DATA_W-1:0] lock_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            s1 <= 1'b1;
            s2 <= 1'b1;
        end else begin
            s1 <= pd_n;
            s2 <= s1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            lock_cnt <= '0;
            blocked  <= 1'b0;
        end else if (!s2) begin
            lock_cnt <= wait_val;
            blocked  <= 1'b1;
        end else if (lock_cnt != '0) begin
            lock_cnt <= lock_cnt - 1'b1;
        end else begin
            blocked <= 1'b0;
        end
    end

    assign pll_en = s2;

    assert_wait_blocks_R7: assert property (@(posedge clk) disable iff (rst)
        (lock_cnt != '0) |-> blocked);
    assert_pd_blocks_R6: assert property (@(posedge clk) disable iff (rst)
        !pll_en |=> blocked);
endmodule

// File: rtl/clkcfg_gate.sv
module clkcfg_gate
    import clkcfg_pkg::*;
#(
    parameter int N = NUM_OUT
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         pd_n,
    input  logic [N-1:0] lvl,
    input  logic [N-1:0] target,
    output logic [N-1:0] gate,
    output logic [N-1:0] gclk
);
    for (genvar i = 0; i < N; i++) begin : g_out
        always_ff @(posedge clk) begin
            if (rst)
                gate[i] <= 1'b0;
            else if (!lvl[i])
                gate[i] <= target[i];
        end
        assign gclk[i] = lvl[i] & gate[i] & pd_n;
    end

    assert_no_runt_R5: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((gate ^ $past(gate)) & $past(lvl)) == '0);
    assert_gate_follows_R4: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (gate & $past(~target & ~lvl)) == '0);
endmodule

// File: rtl/clkcfg_ctrl.sv
module clkcfg_ctrl
    import clkcfg_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic [FS_W-1:0]    strap_in,
    output logic               pin_oe,
    output logic               strap_done,
    input  logic               wr_en,
    input  logic [ADDR_W-1:0]  wr_addr,
    input  logic [DATA_W-1:0]  wr_data,
    input  logic [ADDR_W-1:0]  rd_addr,
    output logic [DATA_W-1:0]  rd_data,
    input  logic               pd_n,
    input  logic               sel_in,
    output logic               sel24,
    input  logic [NUM_OUT-1:0] clk_lvl,
    output logic [NUM_OUT-1:0] gate_en,
    output logic [NUM_OUT-1:0] gclk,
    output logic [FS_W-1:0]    fs_code,
    output logic               pll_en
);
    cfg_t               cfg;
    logic [FS_W-1:0]    strap_q;
    logic               blocked;
    logic [NUM_OUT-1:0] target;

    clkcfg_strap u_strap (
        .clk(clk), .rst(rst), .strap_in(strap_in),
        .strap_q(strap_q), .done(strap_done)
    );

    clkcfg_regs u_regs (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .cfg(cfg)
    );

    clkcfg_pwr u_pwr (
        .clk(clk), .rst(rst), .pd_n(pd_n), .wait_val(cfg.lock_wait),
        .pll_en(pll_en), .blocked(blocked)
    );

    assign target = en_vector(cfg) & {NUM_OUT{strap_done & ~blocked}};

    clkcfg_gate u_gate (
        .clk(clk), .rst(rst), .pd_n(pd_n), .lvl(clk_lvl),
        .target(target), .gate(gate_en), .gclk(gclk)
    );

    always_ff @(posedge clk) begin
        if (rst) sel24 <= 1'b0;
        else     sel24 <= sel_in;
    end

    assign pin_oe  = strap_done;
    assign fs_code = pick_code(cfg, strap_q);

    assert_oe_waits_R1: assert property (@(posedge clk) disable iff (rst)
        !strap_done |-> (gate_en == '0));
endmodule

// File: tb/clkcfg_ctrl_bench.sv
`timescale 1ns/1ps
module clkcfg_ctrl_bench;
    logic        clk = 1'b0;
    logic        rst;
    logic [4:0]  strap_in;
    logic        pin_oe, strap_done;
    logic        wr_en;
    logic [2:0]  wr_addr, rd_addr;
    logic [7:0]  wr_data, rd_data;
    logic        pd_n, sel_in, sel24, pll_en;
    logic [17:0] clk_lvl, gate_en, gclk;
    logic [4:0]  fs_code;

    int checks = 0;
    int fails  = 0;

    clkcfg_ctrl u_clkcfg_ctrl (
        .clk(clk), .rst(rst), .strap_in(strap_in), .pin_oe(pin_oe),
        .strap_done(strap_done), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .pd_n(pd_n), .sel_in(sel_in), .sel24(sel24), .clk_lvl(clk_lvl),
        .gate_en(gate_en), .gclk(gclk), .fs_code(fs_code), .pll_en(pll_en)
    );

    always #2.5 clk = ~clk;

    // {reg0 value, strap, expected code}
    localparam logic [17:0] VEC [6] = '{
        {8'h00, 5'h13, 5'h13},
        {8'h08, 5'h1F, 5'h00},
        {8'hF8, 5'h05, 5'h0F},
        {8'hFC, 5'h00, 5'h1F},
        {8'h5C, 5'h0A, 5'h15},
        {8'hF4, 5'h09, 5'h09}
    };

    task automatic tick(input int n = 1);
        repeat (n) begin
            @(posedge clk);
            #1;
        end
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_reset(input logic [4:0] s);
        rst = 1'b1; strap_in = s; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
        rd_addr = '0; pd_n = 1'b1; sel_in = 1'b0; clk_lvl = '0;
        tick(3);
        rst = 1'b0;
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        tick();
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] d);
        rd_addr = a;
        #0.5;
        d = rd_data;
    endtask

    initial begin
        #900000;
        fails++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        logic [7:0] d;

        // R1 and R3: reset and strap timing
        do_reset(5'h16);
        tick();
        chk("R1 done after edge1", {31'd0, strap_done}, 32'd0);
        chk("R1 oe after edge1", {31'd0, pin_oe}, 32'd0);
        strap_in = 5'h0B;
        tick();
        chk("R1 done after edge2", {31'd0, strap_done}, 32'd1);
        chk("R1 oe after edge2", {31'd0, pin_oe}, 32'd1);
        chk("R1 latched code", {27'd0, fs_code}, 32'h0B);
        strap_in = 5'h04;
        tick(3);
        chk("R1 strap ignored later", {27'd0, fs_code}, 32'h0B);
        chk("R4 all gates on after sampling", {14'd0, gate_en}, 32'h3FFFF);
        rd(3'd0, d); chk("R3 reg0 reset", {24'd0, d}, 32'h00);
        rd(3'd1, d); chk("R3 reg1 reset", {24'd0, d}, 32'h0F);
        rd(3'd2, d); chk("R3 reg2 reset", {24'd0, d}, 32'hFF);
        rd(3'd3, d); chk("R3 reg3 reset", {24'd0, d}, 32'h07);
        rd(3'd4, d); chk("R3 reg4 reset", {24'd0, d}, 32'h07);
        rd(3'd5, d); chk("R3 reg5 reset", {24'd0, d}, 32'h04);
        rd(3'd6, d); chk("R8 reg6 reads zero", {24'd0, d}, 32'h00);
        wr(3'd1, 8'hFF);
        rd(3'd1, d); chk("R3 unimplemented bits zero", {24'd0, d}, 32'h0F);

        // R2: source-select vectors
        for (int i = 0; i < 6; i++) begin
            do_reset(VEC[i][9:5]);
            tick(2);
            wr(3'd0, VEC[i][17:10]);
            chk($sformatf("R2 vector %0d", i), {27'd0, fs_code}, {27'd0, VEC[i][4:0]});
        end

        // R4: enable write and gated output
        do_reset(5'h00);
        tick(3);
        wr(3'd1, 8'h0A);
        chk("R4 gate not yet updated", {28'd0, gate_en[3:0]}, 32'hF);
        tick();
        chk("R4 processor gates", {28'd0, gate_en[3:0]}, 32'hA);
        clk_lvl = '1;
        #0.5;
        chk("R4 disabled outputs low", {28'd0, gclk[3:0]}, 32'hA);

        // R5: gates hold while source high
        wr(3'd2, 8'h00);
        tick(3);
        chk("R5 gate holds while high", {24'd0, gate_en[11:4]}, 32'hFF);
        clk_lvl = '0;
        tick();
        chk("R5 gate drops when low", {24'd0, gate_en[11:4]}, 32'h00);
        wr(3'd2, 8'h3C);
        clk_lvl[11:4] = 8'h0F;
        tick();
        chk("R5 per-output low phase", {24'd0, gate_en[11:4]}, 32'h30);

        // R6: power-down forces outputs low
        clk_lvl = '1;
        #0.5;
        chk("R6 outputs before pd", {14'd0, gclk}, {14'd0, gate_en});
        pd_n = 1'b0;
        #0.5;
        chk("R6 outputs low at once", {14'd0, gclk}, 32'd0);
        tick();
        chk("R6 pll_en after one edge", {31'd0, pll_en}, 32'd1);
        tick();
        chk("R6 pll_en after two edges", {31'd0, pll_en}, 32'd0);

        // R7: lock wait of 3
        do_reset(5'h00);
        tick(3);
        wr(3'd5, 8'd3);
        pd_n = 1'b0;
        tick(4);
        chk("R7 gates off in pd", {14'd0, gate_en}, 32'd0);
        pd_n = 1'b1;
        tick(2);
        chk("R7 pll_en back", {31'd0, pll_en}, 32'd1);
        tick(4);
        chk("R7 gates still off at edge 5", {14'd0, gate_en}, 32'd0);
        tick();
        chk("R7 gates on at edge 6", {14'd0, gate_en}, 32'h3FFFF);

        // R8: reserved writes
        wr(3'd6, 8'h5A);
        wr(3'd7, 8'hA5);
        tick();
        rd(3'd6, d); chk("R8 addr6 reads zero", {24'd0, d}, 32'h00);
        rd(3'd7, d); chk("R8 addr7 reads zero", {24'd0, d}, 32'h00);
        rd(3'd0, d); chk("R8 reg0 untouched", {24'd0, d}, 32'h00);
        rd(3'd5, d); chk("R8 reg5 untouched", {24'd0, d}, 32'h03);
        chk("R8 gates untouched", {14'd0, gate_en}, 32'h3FFFF);
        chk("R8 code untouched", {27'd0, fs_code}, 32'h00);

        // R9: 24/48 select
        sel_in = 1'b1;
        #0.5;
        chk("R9 not before edge", {31'd0, sel24}, 32'd0);
        tick();
        chk("R9 select 24", {31'd0, sel24}, 32'd1);
        sel_in = 1'b0;
        tick();
        chk("R9 select 48", {31'd0, sel24}, 32'd0);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule